// File: doc/BRIEF.md
# Grouped Clock Output Gating and Power-Down Sequencer

This block sits between the internal clock sources of a clock generator and its output pins. It divides one fast clock into seven phase sources: processor, memory, fixed 66 MHz, PCI, APIC, 48 MHz and reference. Each output then passes through a glitch-free gate that is driven by a per-output enable bit and by a power-down sequencer. A two-bit mode select picks the divider set. The modes are all outputs high-impedance, test mode (every rate a fixed ratio of one test clock), 66 MHz processor and 100 MHz processor. In the two normal modes the memory clock runs at 100 MHz.

After reset, a power-up window holds every output low and every driver disabled. Throughout that window the shared reference pin acts as an input. In the window's last cycle the block latches the level on that pin, and this strap picks the APIC ratio. The active-low power-down input is asynchronous. The block synchronises it, then qualifies it on processor-clock rising edges before it shuts the outputs down at a falling edge. Release from power-down follows the same qualified path.

Rates are modelled as counts of the fast clock. One fast-clock cycle stands for the time unit of the simulation model. A period of 4 cycles stands for 100 MHz, 6 for 66 MHz, 12 for 33 MHz, 8 for 48 MHz and 28 for the 14.318 MHz reference. In test mode the test clock stands for a period of 2 cycles.

Top module: `clk_out_sequencer`

## Requirements
- R1: With `sel` = 2'b00, every output-enable port is 0 and every clock output is 0.
- R2: With `sel` = 2'b11 and all enables set, the periods in fast-clock cycles are: processor 4, memory 4, fixed-66 6, PCI 12, USB and dot 8, reference 28.
- R3: With `sel` = 2'b10, the processor period is 6 and the memory period stays 4.
- R4: With `sel` = 2'b01 (test), the periods are: reference 2, processor 4, memory 4, USB and dot 4, fixed-66 6, PCI 12, APIC 12.
- R5: In the normal modes, a strap latched as 1 gives an APIC period of 12 and a strap latched as 0 gives 24. Every APIC rising edge falls in the same cycle as a PCI rising edge.
- R6: For `PWRUP_CYC` cycles after reset, all output enables and all clock outputs are 0. `strap_i` is latched in the last cycle of that window, after which the output enables go to 1.
- R7: With `sel` = 2'b11, processor output 0 is always the inverse of memory output 0.
- R8: An enable bit at 0 holds its output low with no toggling. The bit map is: `en_mem[i]` gates `mem_o[i]`, `en_pci[i]` gates `pci_o[i+1]`, `en_cpu_aux` gates `cpu_o[CPU_N-1]`, and `en_usb` / `en_dot` gate `usb_o` / `dot_o`. `pci_o[0]` and the other processor outputs have no enable.
- R9: Power-down is entered only after the two-flop synchronised `pwrdn_n` has been seen low on two consecutive processor-phase rising edges. From the next falling edge, every clock output stays low while the output enables stay 1.
- R10: Power-down is left only after the synchronised input has been seen high on two consecutive processor-phase rising edges. The outputs then resume with full-width pulses.
- R11: Changing an enable bit or the power-down state never shortens a high pulse. Every pulse has the full high time of its rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast simulation clock that all groups are divided from |
| rst | input | 1 | Synchronous active-high reset; starts the power-up window |
| sel | input | 2 | Mode select: 00 off, 01 test, 10 66 MHz processor, 11 100 MHz processor |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| strap_i | input | 1 | Level seen on the shared reference pin while it acts as an input |
| en_cpu_aux | input | 1 | Enable for the last processor output |
| en_usb | input | 1 | Enable for the USB 48 MHz output |
| en_dot | input | 1 | Enable for the dot 48 MHz output |
| en_mem | input | MEM_N | Per-output memory clock enables |
| en_pci | input | PCI_N-1 | Enables for PCI outputs 1 and up |
| cpu_o | output | CPU_N | Processor clocks |
| cpu_oe | output | 1 | Processor group driver enable |
| mem_o | output | MEM_N | Memory clocks |
| mem_oe | output | 1 | Memory group driver enable |
| f66_o | output | F66_N | Fixed 66 MHz clocks |
| f66_oe | output | 1 | Fixed 66 MHz group driver enable |
| pci_o | output | PCI_N | PCI clocks |
| pci_oe | output | 1 | PCI group driver enable |
| apic_o | output | APIC_N | APIC clocks |
| apic_oe | output | 1 | APIC group driver enable |
| usb_o | output | 1 | USB 48 MHz clock |
| dot_o | output | 1 | Dot 48 MHz clock |
| f48_oe | output | 1 | 48 MHz group driver enable |
| ref_o | output | 1 | Reference clock |
| ref_oe | output | 1 | Reference driver enable; 0 while the pin acts as the strap input |

## Verification
The properties assume that `sel` changes only while `rst` is high. A mode change outside reset restarts the dividers and may cut a pulse short. They also assume that `strap_i` holds steady through the power-up window. The stimulus respects both assumptions: it applies every new mode and strap level only inside a reset pulse. `pwrdn_n` and the enable bits change on falling clock edges at arbitrary points in the output phase. This exercises the synchroniser and the low-phase gating without making any result depend on process order at an edge.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    // width of the half-period counters
    localparam int HW = 6;
    typedef logic [HW-1:0] half_t;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_TEST = 2'b01,
        SEL_66   = 2'b10,
        SEL_100  = 2'b11
    } sel_e;

    // half periods in fast-clock cycles, normal modes
    localparam half_t H_MEM    = half_t'(2);
    localparam half_t H_CPU100 = half_t'(2);
    localparam half_t H_CPU66  = half_t'(3);
    localparam half_t H_F66    = half_t'(3);
    localparam half_t H_PCI    = half_t'(2 * H_F66);
    localparam half_t H_F48    = half_t'(4);
    localparam half_t H_REF    = half_t'(14);
    // half period of the test clock; all test rates are ratios of it
    localparam half_t H_TST    = half_t'(1);

    // divider indices
    localparam int NDIV   = 7;
    localparam int D_CPU  = 0;
    localparam int D_MEM  = 1;
    localparam int D_F66  = 2;
    localparam int D_PCI  = 3;
    localparam int D_APIC = 4;
    localparam int D_F48  = 5;
    localparam int D_REF  = 6;

    typedef struct packed {
        half_t cpu;
        half_t mem;
        half_t f66;
        half_t pci;
        half_t apic;
        half_t f48;
        half_t refc;
        logic  cpu_lag;   // processor phase starts low (half-cycle shift)
    } plan_t;

    function automatic plan_t pick_plan(sel_e m, logic apic_full);
        plan_t p;
        if (m == SEL_TEST || m == SEL_OFF) begin
            p.cpu     = half_t'(2 * H_TST);
            p.mem     = half_t'(2 * H_TST);
            p.f66     = half_t'(3 * H_TST);
            p.pci     = half_t'(6 * H_TST);
            p.apic    = half_t'(6 * H_TST);
            p.f48     = half_t'(2 * H_TST);
            p.refc    = H_TST;
            p.cpu_lag = 1'b0;
        end else begin
            p.cpu     = (m == SEL_100) ? H_CPU100 : H_CPU66;
            p.mem     = H_MEM;
            p.f66     = H_F66;
            p.pci     = H_PCI;
            p.apic    = apic_full ? H_PCI : half_t'(2 * H_PCI);
            p.f48     = H_F48;
            p.refc    = H_REF;
            p.cpu_lag = (m == SEL_100);
        end
        return p;
    endfunction

endpackage

// File: rtl/clkseq_div.sv
module clkseq_div #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         init,
    input  logic [W-1:0] half,
    output logic         ph
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
            ph  <= init;
        end else if (cnt == half - W'(1)) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/clkseq_gate.sv
module clkseq_gate #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         ph,
    input  logic         pd,
    input  logic [N-1:0] en,
    output logic [N-1:0] o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic run_q;
        // the run flag may only change while the phase is low
        always_ff @(posedge clk) begin
            if (rst || hold)
                run_q <= 1'b0;
            else if (!ph)
                run_q <= en[i] & ~pd;
        end
        assign o[i] = ph & run_q;
    end
endmodule

// File: rtl/clkseq_pdseq.sv
module clkseq_pdseq #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_n,
    input  logic step,
    output logic pd_q,
    output logic sync_n
);
    localparam int CW = $clog2(QUAL + 1);

    logic         s1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            sync_n <= 1'b1;
        end else begin
            s1     <= pwrdn_n;
            sync_n <= s1;
        end
    end

    // sync_n == pd_q means the input asks for the other state
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q <= 1'b0;
            cnt  <= '0;
        end else if (step) begin
            if (sync_n == pd_q) begin
                if (cnt == CW'(QUAL - 1)) begin
                    pd_q <= ~pd_q;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/clkseq_pwrup.sv
module clkseq_pwrup #(
    parameter int WAIT = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_i,
    output logic ready,
    output logic strap_q
);
    localparam int CW = $clog2(WAIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ready   <= 1'b0;
            strap_q <= 1'b0;
        end else if (!ready) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(WAIT - 1)) begin
                ready   <= 1'b1;
                strap_q <= strap_i;
            end
        end
    end
endmodule

// File: rtl/clk_out_sequencer.sv
module clk_out_sequencer
    import clkseq_pkg::*;
#(
    parameter int CPU_N     = 3,
    parameter int MEM_N     = 8,
    parameter int F66_N     = 2,
    parameter int PCI_N     = 8,
    parameter int APIC_N    = 2,
    parameter int PWRUP_CYC = 16384,
    parameter int QUAL      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              pwrdn_n,
    input  logic              strap_i,
    input  logic              en_cpu_aux,
    input  logic              en_usb,
    input  logic              en_dot,
    input  logic [MEM_N-1:0]  en_mem,
    input  logic [PCI_N-2:0]  en_pci,
    output logic [CPU_N-1:0]  cpu_o,
    output logic              cpu_oe,
    output logic [MEM_N-1:0]  mem_o,
    output logic              mem_oe,
    output logic [F66_N-1:0]  f66_o,
    output logic              f66_oe,
    output logic [PCI_N-1:0]  pci_o,
    output logic              pci_oe,
    output logic [APIC_N-1:0] apic_o,
    output logic              apic_oe,
    output logic              usb_o,
    output logic              dot_o,
    output logic              f48_oe,
    output logic              ref_o,
    output logic              ref_oe
);
    sel_e            mode_q;
    logic            ready;
    logic            strap_q;
    logic            hold;
    logic            pd_q;
    logic            sync_n;
    logic            cpu_ph_d;
    logic            step;
    logic            oe_all;
    plan_t           plan;
    half_t           halves [NDIV];
    logic [NDIV-1:0] inits;
    logic [NDIV-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= SEL_OFF;
        else     mode_q <= sel_e'(sel);
    end

    clkseq_pwrup #(.WAIT(PWRUP_CYC)) u_pwrup (
        .clk(clk), .rst(rst), .strap_i(strap_i),
        .ready(ready), .strap_q(strap_q)
    );

    assign hold   = !ready || (mode_q != sel_e'(sel)) || (mode_q == SEL_OFF);
    assign oe_all = ready && (mode_q != SEL_OFF);
    assign plan   = pick_plan(mode_q, strap_q);

    always_comb begin
        halves[D_CPU]  = plan.cpu;
        halves[D_MEM]  = plan.mem;
        halves[D_F66]  = plan.f66;
        halves[D_PCI]  = plan.pci;
        halves[D_APIC] = plan.apic;
        halves[D_F48]  = plan.f48;
        halves[D_REF]  = plan.refc;
        inits          = '1;
        inits[D_CPU]   = ~plan.cpu_lag;
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        clkseq_div #(.W(HW)) u_div (
            .clk(clk), .rst(rst), .hold(hold),
            .init(inits[g]), .half(halves[g]), .ph(ph[g])
        );
    end

    // processor-phase rising edges drive the power-down qualifier
    always_ff @(posedge clk) begin
        if (rst) cpu_ph_d <= 1'b0;
        else     cpu_ph_d <= ph[D_CPU];
    end
    assign step = ph[D_CPU] & ~cpu_ph_d & ~hold;

    clkseq_pdseq #(.QUAL(QUAL)) u_pd (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .step(step),
        .pd_q(pd_q), .sync_n(sync_n)
    );

    logic [CPU_N-1:0] cpu_en;
    logic [PCI_N-1:0] pci_en;
    logic [1:0]       f48_v;
    logic [0:0]       ref_v;

    assign cpu_en = {en_cpu_aux, {(CPU_N-1){1'b1}}};
    assign pci_en = {en_pci, 1'b1};

    clkseq_gate #(.N(CPU_N)) u_g_cpu (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_CPU]), .pd(pd_q),
        .en(cpu_en), .o(cpu_o));
    clkseq_gate #(.N(MEM_N)) u_g_mem (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_MEM]), .pd(pd_q),
        .en(en_mem), .o(mem_o));
    clkseq_gate #(.N(F66_N)) u_g_f66 (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_F66]), .pd(pd_q),
        .en({F66_N{1'b1}}), .o(f66_o));
    clkseq_gate #(.N(PCI_N)) u_g_pci (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_PCI]), .pd(pd_q),
        .en(pci_en), .o(pci_o));
    clkseq_gate #(.N(APIC_N)) u_g_apic (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_APIC]), .pd(pd_q),
        .en({APIC_N{1'b1}}), .o(apic_o));
    clkseq_gate #(.N(2)) u_g_f48 (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_F48]), .pd(pd_q),
        .en({en_dot, en_usb}), .o(f48_v));
    clkseq_gate #(.N(1)) u_g_ref (
        .clk(clk), .rst(rst), .hold(hold), .ph(ph[D_REF]), .pd(pd_q),
        .en(1'b1), .o(ref_v));

    assign usb_o   = f48_v[0];
    assign dot_o   = f48_v[1];
    assign ref_o   = ref_v[0];

    assign cpu_oe  = oe_all;
    assign mem_oe  = oe_all;
    assign f66_oe  = oe_all;
    assign pci_oe  = oe_all;
    assign apic_oe = oe_all;
    assign f48_oe  = oe_all;
    assign ref_oe  = oe_all;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel,
    input logic       ready,
    input logic       pd_q,
    input logic       sync_n,
    input logic       any_oe,
    input logic       any_out,
    input logic       cpu0,
    input logic       mem0,
    input logic       en_mem0,
    input logic       pci0,
    input logic       apic0
);
    // R1: off mode disables every driver one cycle later
    p_offmode_r1: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b00) |=> !any_oe);

    // R6: nothing drives or toggles before the power-up window ends
    p_pwrup_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!any_oe && !any_out));

    // R8: a disabled output that is low stays low
    p_disabled_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_mem0 && !mem0) |=> !mem0);

    // R9: power-down entry needs the synchronised request seen low
    p_pd_entry_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_q) |-> !$past(sync_n));

    // R10: power-down exit needs the synchronised request seen high
    p_pd_exit_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_q) |-> $past(sync_n));

    // R9: once low in power-down the processor clock stays low
    p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pd_q && !cpu0) |=> !cpu0);

    // R11: no processor or PCI high pulse shorter than two cycles
    p_cpu_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu0) |=> cpu0);
    p_pci_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(pci0) |=> pci0);

    // R5: APIC rising edges coincide with PCI rising edges
    p_apic_sync_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(apic0) |-> $rose(pci0));
endmodule

bind clk_out_sequencer clkseq_chk u_chk (
    .clk(clk),
    .rst(rst),
    .sel(sel),
    .ready(ready),
    .pd_q(pd_q),
    .sync_n(sync_n),
    .any_oe(cpu_oe | mem_oe | f66_oe | pci_oe | apic_oe | f48_oe | ref_oe),
    .any_out((|cpu_o) | (|mem_o) | (|f66_o) | (|pci_o) | (|apic_o) | usb_o | dot_o | ref_o),
    .cpu0(cpu_o[0]),
    .mem0(mem_o[0]),
    .en_mem0(en_mem[0]),
    .pci0(pci_o[0]),
    .apic0(apic_o[0])
);

// File: tb/sim_clk_out_sequencer.sv
`timescale 1ns/1ps
module sim_clk_out_sequencer;
    localparam int CPU_N = 3, MEM_N = 8, F66_N = 2, PCI_N = 8, APIC_N = 2;
    localparam int PWRUP = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sel = 2'b11;
    logic pwrdn_n = 1'b1;
    logic strap = 1'b1;
    logic en_cpu_aux = 1'b1, en_usb = 1'b1, en_dot = 1'b1;
    logic [MEM_N-1:0] en_mem = '1;
    logic [PCI_N-2:0] en_pci = '1;
    logic [CPU_N-1:0] cpu_o;
    logic [MEM_N-1:0] mem_o;
    logic [F66_N-1:0] f66_o;
    logic [PCI_N-1:0] pci_o;
    logic [APIC_N-1:0] apic_o;
    logic cpu_oe, mem_oe, f66_oe, pci_oe, apic_oe, f48_oe, ref_oe;
    logic usb_o, dot_o, ref_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int    idx;
        int    per;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    clk_out_sequencer #(
        .CPU_N(CPU_N), .MEM_N(MEM_N), .F66_N(F66_N), .PCI_N(PCI_N),
        .APIC_N(APIC_N), .PWRUP_CYC(PWRUP), .QUAL(2)
    ) u0 (
        .clk(clk), .rst(rst), .sel(sel), .pwrdn_n(pwrdn_n), .strap_i(strap),
        .en_cpu_aux(en_cpu_aux), .en_usb(en_usb), .en_dot(en_dot),
        .en_mem(en_mem), .en_pci(en_pci),
        .cpu_o(cpu_o), .cpu_oe(cpu_oe), .mem_o(mem_o), .mem_oe(mem_oe),
        .f66_o(f66_o), .f66_oe(f66_oe), .pci_o(pci_o), .pci_oe(pci_oe),
        .apic_o(apic_o), .apic_oe(apic_oe), .usb_o(usb_o), .dot_o(dot_o),
        .f48_oe(f48_oe), .ref_o(ref_o), .ref_oe(ref_oe)
    );

    function automatic logic pick(int idx);
        case (idx)
            0:  return cpu_o[0];
            1:  return cpu_o[CPU_N-1];
            2:  return mem_o[0];
            3:  return mem_o[MEM_N-1];
            4:  return f66_o[0];
            5:  return pci_o[0];
            6:  return pci_o[1];
            7:  return apic_o[0];
            8:  return usb_o;
            9:  return dot_o;
            10: return ref_o;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic any_out();
        return (|cpu_o) | (|mem_o) | (|f66_o) | (|pci_o) | (|apic_o) | usb_o | dot_o | ref_o;
    endfunction

    function automatic logic any_oe();
        return cpu_oe | mem_oe | f66_oe | pci_oe | apic_oe | f48_oe | ref_oe;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // period in cycles between rising edges; per 0 means count rises in a window
    task automatic measure(input int idx, input int per, output int got);
        logic p, c;
        bit   found;
        got = -1;
        p = pick(idx);
        if (per == 0) begin
            got = 0;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                c = pick(idx);
                if (!p && c) got++;
                p = c;
            end
        end else begin
            found = 0;
            for (int i = 0; i < 200 && !found; i++) begin
                @(negedge clk);
                c = pick(idx);
                if (!p && c) found = 1;
                p = c;
            end
            if (found) begin
                for (int n = 1; n < 200; n++) begin
                    @(negedge clk);
                    c = pick(idx);
                    if (!p && c) begin
                        got = n;
                        break;
                    end
                    p = c;
                end
            end
        end
    endtask

    // scoreboard monitor
    initial begin
        int got;
        forever begin
            wait (q.size() > 0);
            measure(q[0].idx, q[0].per, got);
            chk(got == q[0].per, q[0].tag, got, q[0].per);
            void'(q.pop_front());
        end
    end

    task automatic expect_per(input int idx, input int per, input string tag);
        exp_t e;
        e.idx = idx;
        e.per = per;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s, input logic st);
        @(negedge clk);
        rst = 1'b1;
        sel = s;
        strap = st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise(input int idx, output bit seen);
        logic p, c;
        seen = 0;
        p = pick(idx);
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            c = pick(idx);
            if (!p && c) seen = 1;
            p = c;
        end
    endtask

    task automatic high_len(input int idx, input int pre, output int len);
        len = pre;
        while (pick(idx) && len < 100) begin
            @(negedge clk);
            len++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        bit seen;
        int len, rises, bad;

        // R6: power-up window quiet, then drivers on
        do_reset(2'b11, 1'b1);
        bad = 0;
        for (int i = 0; i < PWRUP - 2; i++) begin
            @(negedge clk);
            if (any_oe() || any_out()) bad++;
        end
        chk(bad == 0, "R6 window quiet", bad, 0);
        repeat (8) @(negedge clk);
        chk(ref_oe == 1'b1, "R6 ref driver on", ref_oe, 1);
        chk(cpu_oe == 1'b1, "R6 cpu driver on", cpu_oe, 1);

        // R2 and R5 with strap high
        expect_per(0, 4, "R2 cpu");
        expect_per(2, 4, "R2 mem");
        expect_per(4, 6, "R2 f66");
        expect_per(5, 12, "R2 pci");
        expect_per(8, 8, "R2 usb");
        expect_per(9, 8, "R2 dot");
        expect_per(10, 28, "R2 ref");
        expect_per(7, 12, "R5 apic full");
        drain();

        // R7: processor opposite memory
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (cpu_o[0] == mem_o[0]) bad++;
        end
        chk(bad == 0, "R7 antiphase", bad, 0);

        // R5: APIC rises together with PCI
        wait_rise(7, seen);
        chk(seen && pci_o[0], "R5 apic with pci", pci_o[0], 1);

        // R8: disabled outputs hold low
        @(negedge clk);
        en_mem[MEM_N-1] = 1'b0;
        en_pci[0] = 1'b0;
        en_usb = 1'b0;
        en_cpu_aux = 1'b0;
        repeat (30) @(negedge clk);
        expect_per(3, 0, "R8 mem7 off");
        expect_per(6, 0, "R8 pci1 off");
        expect_per(8, 0, "R8 usb off");
        expect_per(1, 0, "R8 cpu aux off");
        expect_per(2, 4, "R8 mem0 still on");
        expect_per(9, 8, "R8 dot still on");
        drain();
        chk(mem_o[MEM_N-1] == 1'b0, "R8 mem7 low", mem_o[MEM_N-1], 0);

        // R11: first pulse after enable is full width
        en_pci[0] = 1'b1;
        wait_rise(6, seen);
        high_len(6, 0, len);
        chk(seen && len == 6, "R11 enable full pulse", len, 6);
        // R11: disabling mid-pulse keeps the pulse full
        wait_rise(6, seen);
        repeat (2) @(negedge clk);
        en_pci[0] = 1'b0;
        high_len(6, 2, len);
        chk(len == 6, "R11 disable full pulse", len, 6);
        en_pci[0] = 1'b1;
        en_mem = '1;
        en_usb = 1'b1;
        en_cpu_aux = 1'b1;
        expect_per(3, 4, "R11 mem7 resumes");
        drain();

        // R9: power-down entry
        pwrdn_n = 1'b0;
        rises = 0;
        begin
            logic p, c;
            p = cpu_o[0];
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                c = cpu_o[0];
                if (!p && c) rises++;
                p = c;
            end
        end
        chk(rises >= 2 && rises <= 3, "R9 qualifying edges", rises, 2);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (any_out()) bad++;
        end
        chk(bad == 0, "R9 all low", bad, 0);
        chk(cpu_oe && pci_oe && ref_oe, "R9 drivers on", cpu_oe, 1);

        // R10: release and resume
        pwrdn_n = 1'b1;
        len = 0;
        while (!cpu_o[0] && len < 40) begin
            @(negedge clk);
            len++;
        end
        chk(len >= 4 && len < 40, "R10 resume delay", len, 10);
        high_len(0, 0, len);
        chk(len == 2, "R10 full cpu pulse", len, 2);
        expect_per(5, 12, "R10 pci resumes");
        expect_per(10, 28, "R10 ref resumes");
        drain();

        // R3 and R5 with strap low
        do_reset(2'b10, 1'b0);
        repeat (PWRUP + 4) @(negedge clk);
        expect_per(0, 6, "R3 cpu 66");
        expect_per(2, 4, "R3 mem 100");
        expect_per(7, 24, "R5 apic half");
        expect_per(5, 12, "R3 pci");
        drain();

        // R4: test mode
        do_reset(2'b01, 1'b1);
        repeat (PWRUP + 4) @(negedge clk);
        expect_per(10, 2, "R4 ref");
        expect_per(0, 4, "R4 cpu");
        expect_per(2, 4, "R4 mem");
        expect_per(8, 4, "R4 usb");
        expect_per(4, 6, "R4 f66");
        expect_per(5, 12, "R4 pci");
        expect_per(7, 12, "R4 apic");
        drain();

        // R1: off mode
        do_reset(2'b00, 1'b1);
        repeat (PWRUP + 4) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (any_oe() || any_out()) bad++;
        end
        chk(bad == 0, "R1 off mode", bad, 0);

        summary();
        $finish;
    end
endmodule